// File: doc/BRIEF.md
# Segment Selector Address Translator

This block turns a 16-bit segment selector and a 32-bit offset into a 32-bit linear address. When protection is off, or the virtual-8086 flag is set, it applies the shifted-segment rule: the selector times 16 plus the offset. It answers in a single cycle and does not touch memory.

In protected mode the selector picks an 8-byte descriptor from the global table or the local table. The block first checks that the descriptor lies inside the chosen table. If it does, the block fetches the descriptor as two 32-bit words over a request/acknowledge read port, which tolerates any memory latency. It then unpacks the base, the limit and the access-rights byte, and returns the base plus the offset.

A selector that fails the table check does not raise a fault. The block quietly returns the shifted-segment result and raises a fallback flag. Each result comes with a one-cycle `done` pulse and a flag that reports whether the descriptor marks a 32-bit code segment.

Top module: `seg_xlate`

## Requirements
- R1: When `prot_en` is 0 or `v86_en` is 1, an accepted request produces the following results, all registered with `done` high in the cycle right after the `start` edge and with no memory request:
  - `lin_addr` = {sel,4'b0} + offset, modulo 2^32
  - `seg_base` = {sel,4'b0}
  - `seg_limit` = 32'h0000FFFF
  - `seg_ar` = 0
  - `fallback` = 0
- R2: In protected mode, the byte offset of the descriptor is sel & 16'hFFF8, and sel bit 2 picks the table (0 = global, 1 = local). The first read goes to table base + offset and the second read goes to that address + 4.
- R3: A global-table selector is rejected when its byte offset is 0, or when offset + 7 > `gdt_limit`. When offset + 7 equals the limit, the selector is accepted.
- R4: A local-table selector is rejected when `ldt_sel` is 0, or when offset + 7 > `ldt_limit`. When offset + 7 equals the limit, the selector is accepted.
- R5: A rejected selector makes no memory read. It returns the R1 results with `fallback` = 1 and `big32` = 0, and `done` rises one cycle after `start`.
- R6: After a fetch, `seg_base` is assembled from three fields: bits 31:24 come from bits 31:24 of word 1, bits 23:16 come from bits 7:0 of word 1, and bits 15:0 come from bits 31:16 of word 0. `lin_addr` = `seg_base` + offset, modulo 2^32, and `fallback` = 0.
- R7: After a fetch, `seg_ar` is bits 15:8 of word 1. The raw limit is {word1[19:16], word0[15:0]}. When word1 bit 23 is 1, `seg_limit` = {raw,12'hFFF}; otherwise `seg_limit` = raw.
- R8: `big32` equals word1 bit 22 after a fetch. It is 0 for every result that did not fetch a descriptor.
- R9: An accepted protected request makes exactly two reads. `mem_req` stays high, with `mem_addr` unchanged, until `mem_ack`.
- R10: `busy` is high from an accepted fetch until its `done`. A `start` that arrives while `busy` is high is ignored, and it produces no extra `done`. `done` is a one-cycle pulse, and the result outputs hold their values until the next `done`.
- R11: After reset, `done`, `busy`, `mem_req`, `fallback`, `big32` and `lin_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken when `busy` is low |
| sel | input | 16 | Segment selector |
| offset | input | 32 | Offset within the segment |
| prot_en | input | 1 | Protection enabled |
| v86_en | input | 1 | Virtual-8086 mode active |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | 16 | Global table byte limit |
| ldt_sel | input | 16 | Current local-table selector |
| ldt_base | input | 32 | Local table base address |
| ldt_limit | input | 16 | Local table byte limit |
| busy | output | 1 | Descriptor fetch in progress |
| done | output | 1 | One-cycle result strobe |
| lin_addr | output | 32 | Linear address |
| seg_base | output | 32 | Segment base used |
| seg_limit | output | 32 | Byte limit |
| seg_ar | output | 8 | Access-rights byte |
| fallback | output | 1 | Selector rejected, shifted-segment rule used |
| big32 | output | 1 | Descriptor marks a 32-bit code segment |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The vector table covers these cases:
- Real-mode and virtual-8086 requests, including one that wraps past 2^32 and one whose selector would otherwise be valid. These separate the mode gate from the table check.
- Global-table selectors at index 1 with the low selector bits both clear and set.
- Descriptors with and without page granularity, and with the 32-bit flag set and clear. These tell each base and limit field apart and expose a lost shift.
- Selectors whose last byte lands exactly on the table limit and one descriptor beyond it, in both tables. These pin the off-by-one of the bound test.

Directed tests cover:
- A zero local-table selector.
- A null global selector.
- A start issued during a slow fetch, which must be ignored.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int ADDR_W  = 32;
  localparam int SEL_W   = 16;
  localparam int TLIM_W  = 16;
  localparam int WORD_W  = 32;
  localparam int AR_W    = 8;
  localparam int RAWL_W  = 20;
  localparam int PAGE_SH = 12;
  localparam int SEG_SH  = 4;
  localparam int NTBL    = 2;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic [AR_W-1:0]   ar;
    logic              big;
  } seg_info_t;

  // shifted-segment rule, wraps modulo 2^ADDR_W
  function automatic logic [ADDR_W-1:0] seg_shift_addr(input logic [SEL_W-1:0] s,
                                                       input logic [ADDR_W-1:0] off);
    logic [ADDR_W-1:0] sb;
    sb = ADDR_W'({s, SEG_SH'(0)});
    return sb + off;
  endfunction

  // descriptor byte offset inside its table
  function automatic logic [SEL_W-1:0] sel_byte_off(input logic [SEL_W-1:0] s);
    return s & 16'hFFF8;
  endfunction

  // unpack two descriptor words (lo at +0, hi at +4)
  function automatic seg_info_t desc_unpack(input logic [WORD_W-1:0] lo,
                                            input logic [WORD_W-1:0] hi);
    seg_info_t         d;
    logic [RAWL_W-1:0] raw;
    raw     = {hi[19:16], lo[15:0]};
    d.ar    = hi[15:8];
    d.base  = {hi[31:24], hi[7:0], lo[31:16]};
    d.limit = hi[23] ? {raw, {PAGE_SH{1'b1}}} : ADDR_W'(raw);
    d.big   = hi[22];
    return d;
  endfunction
endpackage

// File: rtl/seg_sel_check.sv
module seg_sel_check
  import seg_xlate_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [TLIM_W-1:0] gdt_limit,
  input  logic [SEL_W-1:0]  ldt_sel,
  input  logic [ADDR_W-1:0] ldt_base,
  input  logic [TLIM_W-1:0] ldt_limit,
  output logic              sel_ok,
  output logic [ADDR_W-1:0] desc_addr
);
  logic [SEL_W-1:0]  boff;
  logic [SEL_W:0]    last_byte;
  logic              tsel;
  logic [NTBL-1:0]   tbl_ok;
  logic [ADDR_W-1:0] tbl_addr [NTBL];
  logic [ADDR_W-1:0] tbase    [NTBL];
  logic [TLIM_W-1:0] tlim     [NTBL];
  logic [NTBL-1:0]   tvalid;

  assign boff      = sel_byte_off(sel);
  assign last_byte = {1'b0, boff} + 17'd7;
  assign tsel      = sel[2];

  // slot 0: global table (null selector banned); slot 1: local table (needs a loaded selector)
  assign tbase[0]  = gdt_base;
  assign tlim[0]   = gdt_limit;
  assign tvalid[0] = (boff != '0);
  assign tbase[1]  = ldt_base;
  assign tlim[1]   = ldt_limit;
  assign tvalid[1] = (ldt_sel != '0);

  for (genvar t = 0; t < NTBL; t++) begin : g_tbl
    assign tbl_ok[t]   = tvalid[t] && (last_byte <= {1'b0, tlim[t]});
    assign tbl_addr[t] = tbase[t] + ADDR_W'(boff);
  end

  assign sel_ok    = tbl_ok[tsel];
  assign desc_addr = tbl_addr[tsel];
endmodule

// File: rtl/seg_rd_seq.sv
module seg_rd_seq
  import seg_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] lo_word,
  output logic [WORD_W-1:0] hi_word,
  output logic              fetch_done,
  output logic              in_second,
  output logic              busy
);
  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND} rd_st_t;
  rd_st_t            st;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      lo_q   <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (launch) begin
          addr_q <= desc_addr;
          st     <= S_FIRST;
        end
        S_FIRST: if (mem_ack) begin
          lo_q   <= mem_rdata;
          addr_q <= addr_q + ADDR_W'(4);
          st     <= S_SECOND;
        end
        S_SECOND: if (mem_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req    = (st != S_IDLE);
  assign mem_addr   = addr_q;
  assign busy       = (st != S_IDLE);
  assign in_second  = (st == S_SECOND);
  assign fetch_done = in_second && mem_ack;
  assign lo_word    = lo_q;
  assign hi_word    = mem_rdata;
endmodule

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
  import seg_xlate_pkg::*;
(
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] hi_word,
  output seg_info_t         info
);
  assign info = desc_unpack(lo_word, hi_word);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] offset,
  input  logic              prot_en,
  input  logic              v86_en,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [TLIM_W-1:0] gdt_limit,
  input  logic [SEL_W-1:0]  ldt_sel,
  input  logic [ADDR_W-1:0] ldt_base,
  input  logic [TLIM_W-1:0] ldt_limit,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] lin_addr,
  output logic [ADDR_W-1:0] seg_base,
  output logic [ADDR_W-1:0] seg_limit,
  output logic [AR_W-1:0]   seg_ar,
  output logic              fallback,
  output logic              big32,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);
  // named internal events
  logic              real_mode;
  logic              accept;
  logic              sel_ok;
  logic              launch;
  logic              quick;
  logic              fetch_done;
  logic              seq_in_second;
  logic [ADDR_W-1:0] desc_addr;
  logic [WORD_W-1:0] lo_word;
  logic [WORD_W-1:0] hi_word;
  logic [ADDR_W-1:0] off_q;
  seg_info_t         info;

  assign real_mode = !prot_en || v86_en;
  assign accept    = start && !busy;
  assign launch    = accept && !real_mode && sel_ok;
  assign quick     = accept && (real_mode || !sel_ok);

  seg_sel_check u_chk_sel (
    .sel       (sel),
    .gdt_base  (gdt_base),
    .gdt_limit (gdt_limit),
    .ldt_sel   (ldt_sel),
    .ldt_base  (ldt_base),
    .ldt_limit (ldt_limit),
    .sel_ok    (sel_ok),
    .desc_addr (desc_addr)
  );

  seg_rd_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .desc_addr  (desc_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .lo_word    (lo_word),
    .hi_word    (hi_word),
    .fetch_done (fetch_done),
    .in_second  (seq_in_second),
    .busy       (busy)
  );

  seg_desc_unpack u_unpack (
    .lo_word (lo_word),
    .hi_word (hi_word),
    .info    (info)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q     <= '0;
      done      <= 1'b0;
      lin_addr  <= '0;
      seg_base  <= '0;
      seg_limit <= '0;
      seg_ar    <= '0;
      fallback  <= 1'b0;
      big32     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) off_q <= offset;
      if (quick) begin
        done      <= 1'b1;
        lin_addr  <= seg_shift_addr(sel, offset);
        seg_base  <= seg_shift_addr(sel, '0);
        seg_limit <= ADDR_W'(16'hFFFF);
        seg_ar    <= '0;
        fallback  <= !real_mode;
        big32     <= 1'b0;
      end else if (fetch_done) begin
        done      <= 1'b1;
        lin_addr  <= info.base + off_q;
        seg_base  <= info.base;
        seg_limit <= info.limit;
        seg_ar    <= info.ar;
        fallback  <= 1'b0;
        big32     <= info.big;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
  import seg_xlate_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              prot_en,
  input logic              v86_en,
  input logic [SEL_W-1:0]  sel,
  input logic [ADDR_W-1:0] offset,
  input logic              done,
  input logic              fallback,
  input logic              big32,
  input logic [ADDR_W-1:0] lin_addr,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              in_second
);
  a_r1_real_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (!prot_en || v86_en) |=>
      done && !fallback && !big32 && !mem_req &&
      lin_addr == ({12'd0, $past(sel), 4'd0} + $past(offset)));

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  a_r2_second_word: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !in_second |=>
      mem_req && in_second && mem_addr == $past(mem_addr) + 32'd4);

  a_r8_fallback_not_big: assert property (@(posedge clk) disable iff (!rst_n)
    done && fallback |-> !big32);

  a_r10_no_done_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> !done);

  a_r10_busy_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> mem_req);
endmodule

bind seg_xlate seg_xlate_chk u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .prot_en   (prot_en),
  .v86_en    (v86_en),
  .sel       (sel),
  .offset    (offset),
  .done      (done),
  .fallback  (fallback),
  .big32     (big32),
  .lin_addr  (lin_addr),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .in_second (seq_in_second)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [15:0] sel = 0;
  logic [31:0] offset = 0;
  logic        prot_en = 0, v86_en = 0;
  logic [31:0] gdt_base = 32'h100, ldt_base = 32'h180;
  logic [15:0] gdt_limit = 16'h3F, ldt_limit = 16'h17, ldt_sel = 16'h10;
  logic        busy, done, fallback, big32, mem_req;
  logic [31:0] lin_addr, seg_base, seg_limit, mem_addr;
  logic [7:0]  seg_ar;
  logic        mem_ack = 0;
  logic [31:0] mem_rdata = 0;

  int n_chk = 0, n_fail = 0, cycles = 0;

  always #5 clk = ~clk;

  seg_xlate u_dut (.*);

  // memory model: words at addr[8:2], latency cycles through 0..3
  logic [31:0] mem [0:127];
  int          acks = 0, wcnt = 0, lat = 0;
  logic [31:0] ack_addr [0:7];

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      mem_ack = 0;
    end else if (mem_ack) begin
      mem_ack = 0;
      wcnt = 0;
      lat = (lat + 1) % 4;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack = 1;
        mem_rdata = mem[mem_addr[8:2]];
        ack_addr[acks % 8] = mem_addr;
        acks++;
      end else wcnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // send one request; returns cycles from start edge to done
  task automatic run(input logic [15:0] s, input logic [31:0] o, input logic p,
                     input logic v, output int cyc, output int nacks, output int a0);
    int base_acks;
    @(negedge clk);
    sel = s; offset = o; prot_en = p; v86_en = v; start = 1;
    base_acks = acks;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    cyc = 1;
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    nacks = acks - base_acks;
    a0 = base_acks;
  endtask

  // reference: bytes of the descriptor reassembled
  function automatic logic [7:0] dbyte(input logic [31:0] a, input int k);
    logic [31:0] w;
    w = mem[(a + 32'(k / 4 * 4)) >> 2 & 32'h7F];
    return w[8*(k%4) +: 8];
  endfunction

  typedef struct packed {
    logic [15:0] s;
    logic [31:0] o;
    logic        p;
    logic        v;
    logic        fb;
    logic        big;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{16'h1234, 32'h00005678, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 real
    '{16'hFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 1'b0}, // R1 v86 wrap
    '{16'h0008, 32'h00000010, 1'b1, 1'b0, 1'b0, 1'b1}, // R6 R7 page gran
    '{16'h000B, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b1}, // R2 rpl bits ignored
    '{16'h0010, 32'h00000100, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 byte gran
    '{16'h0038, 32'h00000020, 1'b1, 1'b0, 1'b0, 1'b1}, // R3 boundary, wrap
    '{16'h0040, 32'h00000004, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 past limit
    '{16'h0003, 32'h00000008, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 null
    '{16'h000C, 32'h00000044, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 local
    '{16'h0016, 32'h00000001, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 boundary
    '{16'h001C, 32'h00000002, 1'b1, 1'b0, 1'b1, 1'b0}, // R4 past limit
    '{16'h0008, 32'h00000000, 1'b1, 1'b1, 1'b0, 1'b0}  // R1 v86 gate
  };

  task automatic check_vec(input vec_t t);
    int          cyc, na, a0;
    logic [31:0] da, eb, el, raw;
    logic [7:0]  b6;
    run(t.s, t.o, t.p, t.v, cyc, na, a0);
    if (t.fb || !t.p || t.v) begin
      chk("R1/R5 done latency", 32'(cyc), 32'd1);
      chk("R1/R5 no reads", 32'(na), 32'd0);
      chk("R1/R5 lin_addr", lin_addr, 32'(t.s) * 16 + t.o);
      chk("R1 seg_limit", seg_limit, 32'hFFFF);
      chk("R5 fallback", 32'(fallback), 32'(t.fb));
      chk("R8 big32 zero", 32'(big32), 32'd0);
    end else begin
      da = (t.s[2] ? ldt_base : gdt_base) + 32'(t.s & ~16'h7);
      b6 = dbyte(da, 6);
      eb = {dbyte(da, 7), dbyte(da, 4), dbyte(da, 3), dbyte(da, 2)};
      raw = {12'd0, b6[3:0], dbyte(da, 1), dbyte(da, 0)};
      el = b6[7] ? raw * 4096 + 32'hFFF : raw;
      chk("R9 two reads", 32'(na), 32'd2);
      chk("R2 first read addr", ack_addr[a0 % 8], da);
      chk("R2 second read addr", ack_addr[(a0 + 1) % 8], da + 4);
      chk("R6 seg_base", seg_base, eb);
      chk("R6 lin_addr", lin_addr, eb + t.o);
      chk("R7 seg_limit", seg_limit, el);
      chk("R7 seg_ar", 32'(seg_ar), 32'(dbyte(da, 5)));
      chk("R8 big32", 32'(big32), 32'(t.big));
      chk("R6 fallback clear", 32'(fallback), 32'd0);
    end
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'h0;
    mem[32'h108 >> 2] = 32'h5678BCDE; mem[32'h10C >> 2] = 32'h12CA9A34;
    mem[32'h110 >> 2] = 32'hCDEF1234; mem[32'h114 >> 2] = 32'h000592AB;
    mem[32'h138 >> 2] = 32'hFFF00000; mem[32'h13C >> 2] = 32'hFF40FAFF;
    mem[32'h188 >> 2] = 32'h0000FFFF; mem[32'h18C >> 2] = 32'h00009300;
    mem[32'h190 >> 2] = 32'h10000010; mem[32'h194 >> 2] = 32'h00009200;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 done", 32'(done), 0);
    chk("R11 busy", 32'(busy), 0);
    chk("R11 mem_req", 32'(mem_req), 0);
    chk("R11 lin_addr", lin_addr, 0);
    chk("R11 fallback/big32", 32'({fallback, big32}), 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) check_vec(VT[i]);

    // R10 done is a single-cycle pulse, result held
    @(negedge clk);
    chk("R10 done pulse width", 32'(done), 0);
    chk("R10 result held", 32'(fallback), 32'd0);

    // R4 zero local selector rejects
    ldt_sel = 16'h0;
    check_vec('{16'h000C, 32'h00000044, 1'b1, 1'b0, 1'b1, 1'b0});
    ldt_sel = 16'h10;

    // R10 start during a fetch is ignored
    begin
      int dn, na0;
      @(negedge clk);
      sel = 16'h0008; offset = 32'h10; prot_en = 1; v86_en = 0; start = 1;
      na0 = acks;
      @(negedge clk);
      chk("R10 busy during fetch", 32'(busy), 1);
      sel = 16'h1234; offset = 32'h1; prot_en = 0; start = 1;
      @(negedge clk);
      start = 0;
      dn = 0;
      for (int k = 0; k < 30; k++) begin
        if (done) begin
          dn++;
          chk("R10 fetch result kept", lin_addr, 32'h12345688);
        end
        @(negedge clk);
      end
      chk("R10 single done", 32'(dn), 1);
      chk("R9 reads for one fetch", 32'(acks - na0), 2);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule